// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block is a small, fully associative cache of page translations. It sits between an address source and a page-table walker. A lookup gives a virtual address and an access type. One cycle later the block answers with exactly one of three outcomes:

- a hit, which carries a physical address;
- a miss, which tells the walker to go and fetch the mapping;
- a protection fault, raised when the mapping exists but does not allow that kind of access.

Every valid entry is compared against the virtual page number in parallel, so any page can sit in any slot.

After a miss, the walker writes the mapping through the fill port. A fill chooses its slot in this order:

1. the entry already holding the same page;
2. otherwise the lowest-numbered empty entry;
3. otherwise the least recently used entry.

When a different page is pushed out, its page number and dirty state are reported the next cycle so that write-back can be arranged. A write that succeeds marks its entry dirty. A flush input empties the whole buffer in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: Every lookup strobe is answered exactly one cycle later with `rsp_valid` high and exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high; with no strobe, all four are low.
- R2: On a hit, `rsp_paddr` is the entry's 20-bit physical page number in bits 31:12, and the 12-bit page offset of the virtual address, unchanged, in bits 11:0.
- R3: A lookup whose virtual page number (address bits 31:12) matches no valid entry reports a miss with `rsp_paddr` zero.
- R4: A read needs the entry's read permission and a write needs its write permission. Otherwise the lookup reports a fault with `rsp_paddr` zero. A faulting lookup neither sets the dirty bit nor counts as a use for replacement.
- R5: A write hit sets the entry's dirty bit. When that entry is later displaced by a fill, `evict_dirty` is 1; a freshly filled entry starts clean.
- R6: A fill of a page not already present goes to the lowest-indexed invalid entry, and `evict_valid` stays low.
- R7: When all entries are valid, a fill of a new page replaces the least recently used entry. Successful hits and fills count as uses. The cycle after the fill, `evict_valid` is 1 and `evict_vpn` gives the displaced page.
- R8: A fill of a page that is already present overwrites that entry's physical page number and permissions in place, clears its dirty bit, and raises no eviction.
- R9: A flush invalidates every entry. A lookup in the flush cycle reports a miss, and a fill in the flush cycle is dropped.
- R10: After reset the buffer holds no valid entry and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation returned |
| rsp_miss | output | 1 | No valid mapping |
| rsp_fault | output | 1 | Mapping present, access not permitted |
| rsp_paddr | output | 32 | Physical address on hit, else zero |
| fill_en | input | 1 | Write a mapping |
| fill_vpn | input | 20 | Virtual page number of the mapping |
| fill_ppn | input | 20 | Physical page number of the mapping |
| fill_rd_ok | input | 1 | Read permission of the mapping |
| fill_wr_ok | input | 1 | Write permission of the mapping |
| evict_valid | output | 1 | Previous fill displaced another valid page |
| evict_vpn | output | 20 | Page number of the displaced entry |
| evict_dirty | output | 1 | Displaced entry had been written |

## Verification
The hardest condition to reach from the ports is a full buffer whose recency order has been reshaped by hits. Faulting accesses interleave with those hits and must not disturb that order. The condition is then exposed only by which page a later fill pushes out.

The bench keeps a shadow of the buffer in which each slot stores the time of its last successful use. It runs a long deterministic pseudo-random mix of reads, writes and fills over a page pool larger than the buffer. This mix repeatedly forces evictions after varied hit patterns, and each displaced page and its dirty state are checked against the shadow.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int PPN_W   = 20,
  localparam int VPN_W  = VA_W - PG_BITS,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W   = PPN_W + PG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd_ok,
  input  logic             fill_wr_ok,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic             evict_dirty
);

  logic [ENTRIES-1:0] e_vld, e_dty, e_rd, e_wr;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  logic [IDX_W-1:0]   e_age [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fl_match, old_vec;
  wire  [VPN_W-1:0]   lk_vpn = lk_vaddr[VA_W-1:PG_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = e_vld[g] && (e_vpn[g] == lk_vpn);
    assign fl_match[g] = e_vld[g] && (e_vpn[g] == fill_vpn);
    assign old_vec[g]  = (e_age[g] == IDX_W'(ENTRIES - 1));
  end

  function automatic logic [IDX_W-1:0] lowest(input logic [ENTRIES-1:0] v);
    lowest = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) lowest = IDX_W'(i);
  endfunction

  wire             lk_hit  = |lk_match;
  wire [IDX_W-1:0] lk_idx  = lowest(lk_match);
  wire             lk_ok   = lk_write ? e_wr[lk_idx] : e_rd[lk_idx];
  wire             acc_go  = lk_valid && !flush && lk_hit && lk_ok;
  wire             acc_bad = lk_valid && !flush && lk_hit && !lk_ok;

  wire             fill_go  = fill_en && !flush;
  wire             same_pg  = |fl_match;
  wire [IDX_W-1:0] vic_idx  = same_pg ? lowest(fl_match)
                            : (~e_vld != '0) ? lowest(~e_vld)
                            : lowest(old_vec);
  wire             displace = fill_go && !same_pg && e_vld[vic_idx];

  wire             touch_en  = fill_go || acc_go;
  wire [IDX_W-1:0] touch_idx = fill_go ? vic_idx : lk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
      e_dty <= '0;
      e_rd  <= '0;
      e_wr  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_vpn[i] <= '0;
        e_ppn[i] <= '0;
        e_age[i] <= IDX_W'(i);
      end
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_miss    <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_dirty <= 1'b0;
    end else begin
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++)
          if (IDX_W'(i) == touch_idx)             e_age[i] <= '0;
          else if (e_age[i] < e_age[touch_idx])  e_age[i] <= e_age[i] + 1'b1;

      if (flush) e_vld <= '0;
      if (acc_go && lk_write) e_dty[lk_idx] <= 1'b1;
      if (fill_go) begin
        e_vld[vic_idx] <= 1'b1;
        e_dty[vic_idx] <= 1'b0;
        e_rd[vic_idx]  <= fill_rd_ok;
        e_wr[vic_idx]  <= fill_wr_ok;
        e_vpn[vic_idx] <= fill_vpn;
        e_ppn[vic_idx] <= fill_ppn;
      end

      rsp_valid <= lk_valid;
      rsp_hit   <= acc_go;
      rsp_fault <= acc_bad;
      rsp_miss  <= lk_valid && (flush || !lk_hit);
      rsp_paddr <= acc_go ? {e_ppn[lk_idx], lk_vaddr[PG_BITS-1:0]} : '0;

      evict_valid <= displace;
      evict_vpn   <= displace ? e_vpn[vic_idx] : '0;
      evict_dirty <= displace && e_dty[vic_idx];
    end
  end

endmodule

module xlat_cache_chk #(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int PPN_W   = 20,
  localparam int VPN_W  = VA_W - PG_BITS,
  localparam int PA_W   = PPN_W + PG_BITS
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             fill_en,
  input logic             evict_valid,
  input logic [VPN_W-1:0] evict_vpn
);
  // R1
  resp_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  // R1
  no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault);
  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_paddr[PG_BITS-1:0] == $past(lk_vaddr[PG_BITS-1:0])));
  // R3
  no_addr_unless_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_miss || rsp_fault) |-> rsp_paddr == '0);
  // R9
  flush_forces_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && lk_valid) |=> rsp_miss);
  // R9
  flush_blocks_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !evict_valid);
  // R7
  evict_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> $past(fill_en));
  // R7
  quiet_evict_vpn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_valid |-> evict_vpn == '0);
endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PG_BITS(PG_BITS), .PPN_W(PPN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .fill_en(fill_en), .evict_valid(evict_valid), .evict_vpn(evict_vpn)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        fill_rd_ok = 1'b0;
  logic        fill_wr_ok = 1'b0;
  logic        evict_valid, evict_dirty;
  logic [19:0] evict_vpn;

  always #4 clk = ~clk;

  xlat_cache dut_i (.*);

  int n_chk = 0;
  int n_err = 0;

  logic        m_v [8];
  logic        m_r [8];
  logic        m_w [8];
  logic        m_d [8];
  logic [19:0] m_vpn [8];
  logic [19:0] m_ppn [8];
  int          m_ts [8];
  int          now = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] vpn, input logic [11:0] off, input bit wr);
    int j = -1;
    logic [35:0] exp;
    string tag;
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) j = i;
    if (j < 0) begin
      exp = {4'b1010, 32'h0}; tag = "R3";
    end else if (wr ? m_w[j] : m_r[j]) begin
      exp = {4'b1100, m_ppn[j], off}; tag = "R2";
      now++; m_ts[j] = now;
      if (wr) m_d[j] = 1'b1;
    end else begin
      exp = {4'b1001, 32'h0}; tag = "R4";
    end
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_write = wr;
    @(negedge clk);
    lk_valid = 1'b0;
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr} == exp, tag,
          64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}), 64'(exp));
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit r, input bit w);
    int j = -1;
    logic [21:0] exp;
    string tag;
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) j = i;
    if (j >= 0) begin
      exp = '0; tag = "R8";
    end else begin
      for (int i = 7; i >= 0; i--) if (!m_v[i]) j = i;
      if (j >= 0) begin
        exp = '0; tag = "R6";
      end else begin
        j = 0;
        for (int i = 1; i < 8; i++) if (m_ts[i] < m_ts[j]) j = i;
        exp = {1'b1, m_vpn[j], m_d[j]};
        tag = m_d[j] ? "R5" : "R7";
      end
    end
    m_v[j] = 1'b1; m_vpn[j] = vpn; m_ppn[j] = ppn; m_r[j] = r; m_w[j] = w; m_d[j] = 1'b0;
    now++; m_ts[j] = now;
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rd_ok = r; fill_wr_ok = w;
    @(negedge clk);
    fill_en = 1'b0;
    check({evict_valid, evict_vpn, evict_dirty} == exp, tag,
          64'({evict_valid, evict_vpn, evict_dirty}), 64'(exp));
  endtask

  function automatic logic [19:0] pool(input int k);
    return 20'h01000 + 20'(k * 'h35);
  endfunction

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 0; m_d[i] = 0; m_r[i] = 0; m_w[i] = 0;
      m_vpn[i] = '0; m_ppn[i] = '0; m_ts[i] = -i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state at the ports
    check({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr, evict_valid, evict_vpn, evict_dirty} == '0,
          "R10", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr}), 64'h0);
    lookup(20'h00000, 12'h000, 1'b0);
    lookup(pool(0), 12'hfff, 1'b1);

    // R6 fill empty slots with every permission pattern
    for (int i = 0; i < 8; i++) fill(pool(i), 20'hA0000 + 20'(i * 'h111), i[0], i[1]);

    // R2 R4 sweep of pages, access types and offsets
    for (int i = 0; i < 9; i++)
      for (int t = 0; t < 2; t++)
        for (int o = 0; o < 3; o++)
          lookup(pool(i), (o == 0) ? 12'h000 : (o == 1) ? 12'hfff : 12'(i * 'h9d), t[0]);

    // R8 refill in place
    fill(pool(3), 20'h5_5555, 1'b1, 1'b1);
    lookup(pool(3), 12'h123, 1'b1);
    fill(pool(3), 20'h6_6666, 1'b1, 1'b0);
    lookup(pool(3), 12'h456, 1'b1);

    // R5 R7 mixed traffic forcing evictions
    for (int n = 0; n < 600; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      if (lcg[31:29] < 3'd2) fill(pool(int'(lcg[27:24]) % 13), 20'(lcg[19:0]), lcg[5] | lcg[6], lcg[7] | lcg[8]);
      else lookup(pool(int'(lcg[27:24]) % 13), lcg[11:0], lcg[4]);
    end

    // R9 flush with lookup and fill in the same cycle
    @(negedge clk);
    flush = 1'b1; lk_valid = 1'b1; lk_vaddr = {m_vpn[0], 12'h010}; lk_write = 1'b0;
    fill_en = 1'b1; fill_vpn = 20'hF_0F0F; fill_ppn = 20'h1; fill_rd_ok = 1'b1; fill_wr_ok = 1'b1;
    @(negedge clk);
    flush = 1'b0; lk_valid = 1'b0; fill_en = 1'b0;
    check(rsp_miss && !rsp_hit && !rsp_fault && !evict_valid, "R9",
          64'({rsp_hit, rsp_miss, rsp_fault, evict_valid}), 64'b0100);
    for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
    lookup(20'hF_0F0F, 12'h000, 1'b0);
    for (int i = 0; i < 13; i++) lookup(pool(i), 12'h321, 1'b0);
    fill(pool(2), 20'h0_0042, 1'b1, 1'b1);
    lookup(pool(2), 12'hABC, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule